// File: doc/BRIEF.md
# Two-Phase Transition Set/Clear Flag

This block turns two transition-signalled event lines into a single status flag. In two-phase signalling an event is any change of level, in either direction, rather than a pulse. One line, the clear line, takes the flag to 0 every time its level changes. The other line, the set line, takes the flag to 1 every time its level changes. This is the event-detection core that a two-phase request/acknowledge handshake is built on.

The design is fully clocked. Each line passes through a synchroniser of `SYNC_STAGES` flops. A change is found by comparing the synchronised sample with the sample taken one cycle earlier, using an XOR, so rising and falling changes are detected by the same logic. Each line also drives a one-cycle event pulse output. The flag is held in one register, so it has a single driver and uses a single clock edge.

The two lines are meant never to change in the same cycle. If they do, clearing wins. While reset is held, the synchronisers and the previous-sample registers keep following the lines. Releasing reset therefore never produces an event, whatever levels the lines are at.

Top module: `twophase_flag`

## Requirements
- R1: While `rst_n` is low, `flag_o` is 0. After `rst_n` rises, `flag_o` stays 0 until an event occurs.
- R2: A change of level on `clr_line_i`, 0 to 1 or 1 to 0, makes `clr_evt_o` high for exactly one cycle. The pulse is high in the cycle that follows clock edge k+SYNC_STAGES-1, where edge k is the first edge that samples the new level.
- R3: A change of level on `set_line_i`, in either direction, makes `set_evt_o` high for exactly one cycle, with the same timing as R2.
- R4: When `clr_evt_o` is high, `flag_o` is 0 after the next clock edge.
- R5: When `set_evt_o` is high and `clr_evt_o` is low, `flag_o` is 1 after the next clock edge.
- R6: If both lines change in the same cycle, both event pulses fire together and `flag_o` becomes 0.
- R7: In a cycle with no event pulse, `flag_o` keeps its value.
- R8: If a line is held at 1 while `rst_n` is released, neither event pulse fires and `flag_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_line_i | input | 1 | Two-phase line; each change clears the flag |
| set_line_i | input | 1 | Two-phase line; each change sets the flag |
| flag_o | output | 1 | The flag |
| clr_evt_o | output | 1 | One-cycle pulse for each detected change on the clear line |
| set_evt_o | output | 1 | One-cycle pulse for each detected change on the set line |

## Verification
Two situations are hard to reach from the ports. The first is a simultaneous change on both lines. Legal stimulus never produces it, so the bench forces it by driving both lines on the same falling clock edge. It does this as part of a sweep over all sixteen pairs of old and new line levels, which also covers every single-line change in both directions and from both flag values. The second is a line sitting at 1 when reset is released. The bench holds both lines high through a full reset and then watches the event pulses cycle by cycle for any spurious event.

// File: rtl/twophase_pkg.sv
package twophase_pkg;

  localparam int CH_CLR = 0;
  localparam int CH_SET = 1;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_SET   = 2'd2
  } flag_act_e;

  // Clearing wins when both events land in one cycle.
  function automatic flag_act_e pick_action(input logic clr_evt, input logic set_evt);
    if (clr_evt)      return ACT_CLEAR;
    else if (set_evt) return ACT_SET;
    else              return ACT_HOLD;
  endfunction

endpackage

// File: rtl/twophase_sync.sv
module twophase_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  // No reset: the chain keeps tracking the line while reset is held,
  // so its output already matches the line when reset is released.
  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk) chain_q <= {chain_q[LAST-1:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[LAST];

endmodule

// File: rtl/twophase_edge.sv
module twophase_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic evt_o
);
  logic prev_q;
  logic armed_q;

  // The previous sample follows the line at all times, reset included.
  always_ff @(posedge clk) prev_q <= lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign evt_o = armed_q & (lvl_i ^ prev_q);

  assert_evt_tracks_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(armed_q)) |-> (evt_o == (lvl_i != $past(lvl_i))))
    else $error("edge event does not match a level change");

  assert_no_evt_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> (prev_q == $past(lvl_i)))
    else $error("previous sample not primed at reset release");

endmodule

// File: rtl/twophase_flag_reg.sv
module twophase_flag_reg
  import twophase_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_evt_i,
  input  logic set_evt_i,
  output logic flag_o
);
  flag_act_e act;
  logic      flag_q;

  assign act = pick_action(clr_evt_i, set_evt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else begin
      case (act)
        ACT_CLEAR: flag_q <= 1'b0;
        ACT_SET:   flag_q <= 1'b1;
        default:   flag_q <= flag_q;
      endcase
    end
  end

  assign flag_o = flag_q;

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |-> !flag_q)
    else $error("flag not clear in reset");

  assert_clear_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt_i |=> !flag_q)
    else $error("clear event did not clear flag");

  assert_set_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt_i && !clr_evt_i) |=> flag_q)
    else $error("set event did not set flag");

  assert_both_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt_i && clr_evt_i) |=> !flag_q)
    else $error("simultaneous events did not clear flag");

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt_i && !clr_evt_i && $past(rst_n)) |=> $stable(flag_q))
    else $error("flag changed without event");

endmodule

// File: rtl/twophase_flag.sv
module twophase_flag
  import twophase_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_line_i,
  input  logic set_line_i,
  output logic flag_o,
  output logic clr_evt_o,
  output logic set_evt_o
);
  logic [NUM_CH-1:0] line_raw;
  logic [NUM_CH-1:0] line_sync;
  logic [NUM_CH-1:0] line_evt;

  assign line_raw[CH_CLR] = clr_line_i;
  assign line_raw[CH_SET] = set_line_i;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      twophase_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (line_raw[ch]),
        .q_o (line_sync[ch])
      );
      twophase_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (line_sync[ch]),
        .evt_o (line_evt[ch])
      );
    end
  endgenerate

  twophase_flag_reg u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_evt_i (line_evt[CH_CLR]),
    .set_evt_i (line_evt[CH_SET]),
    .flag_o    (flag_o)
  );

  assign clr_evt_o = line_evt[CH_CLR];
  assign set_evt_o = line_evt[CH_SET];

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && set_evt_o && $stable(set_line_i)) |=> !set_evt_o)
    else $error("set event pulse wider than one cycle");

endmodule

// File: tb/twophase_flag_bench.sv
`timescale 1ns/1ps
module twophase_flag_bench;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic clr_line, set_line;
  logic flag, clr_evt, set_evt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic exp_flag;

  always #2.5 clk = ~clk;

  twophase_flag #(.SYNC_STAGES(S)) u_twophase_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_line_i (clr_line),
    .set_line_i (set_line),
    .flag_o     (flag),
    .clr_evt_o  (clr_evt),
    .set_evt_o  (set_evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Change the lines to (c, s) and check the pulse timing and the flag result.
  task automatic step(input logic c, input logic s);
    logic dc, ds, old_flag;
    dc = (c != clr_line);
    ds = (s != set_line);
    old_flag = exp_flag;
    if (dc)      exp_flag = 1'b0;
    else if (ds) exp_flag = 1'b1;
    @(negedge clk);
    clr_line = c;
    set_line = s;
    repeat (S - 1) @(posedge clk);
    @(negedge clk);
    chk(clr_evt == 1'b0, "R2 clear pulse early", clr_evt, 0);
    chk(set_evt == 1'b0, "R3 set pulse early", set_evt, 0);
    @(posedge clk);
    @(negedge clk);
    chk(clr_evt == dc, "R2 clear pulse", clr_evt, dc);
    chk(set_evt == ds, "R3 set pulse", set_evt, ds);
    chk(flag == old_flag, "R7 flag before update", flag, old_flag);
    @(posedge clk);
    @(negedge clk);
    chk(clr_evt == 1'b0, "R2 clear pulse one cycle", clr_evt, 0);
    chk(set_evt == 1'b0, "R3 set pulse one cycle", set_evt, 0);
    if (dc && ds)   chk(flag == exp_flag, "R6 both change clears", flag, exp_flag);
    else if (dc)    chk(flag == exp_flag, "R4 clear line change", flag, exp_flag);
    else if (ds)    chk(flag == exp_flag, "R5 set line change", flag, exp_flag);
    else            chk(flag == exp_flag, "R7 no change holds", flag, exp_flag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clr_line = 1'b0;
    set_line = 1'b0;
    exp_flag = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(flag == 1'b0, "R1 flag in reset", flag, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(flag == 1'b0, "R1 flag after release", flag, 0);
    chk(clr_evt == 1'b0 && set_evt == 1'b0, "R1 no pulse after release", {clr_evt, set_evt}, 0);

    // Sweep every old/new level pair for both lines (bit1 = clear, bit0 = set).
    for (int from = 0; from < 4; from++) begin
      for (int to = 0; to < 4; to++) begin
        step(from[1], from[0]);
        step(to[1], to[0]);
        step(to[1], ~to[0]);  // set event to vary the flag value going in
        step(to[1], to[0]);
      end
    end

    // R8: lines high across reset release produce no event.
    @(negedge clk);
    clr_line = 1'b1;
    set_line = 1'b1;
    rst_n = 1'b0;
    exp_flag = 1'b0;
    repeat (2) @(negedge clk);
    chk(flag == 1'b0, "R1 flag cleared by reset", flag, 0);
    repeat (S + 2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(clr_evt == 1'b0, "R8 no clear pulse after release", clr_evt, 0);
      chk(set_evt == 1'b0, "R8 no set pulse after release", set_evt, 0);
      chk(flag == 1'b0, "R8 flag stays clear", flag, 0);
    end
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);

    done = 1;
    summary();
    $finish;
  end

endmodule